// File: doc/BRIEF.md
# PTP System Time Generator

This block keeps a free-running time of day as a seconds word and a nanoseconds word, in the style used by IEEE 1588 clocks. It does not step the time by a fixed amount on each clock. A 32-bit phase accumulator adds a programmable addend on every enabled cycle. Each carry out of that accumulator adds a programmable sub-second increment to the nanoseconds field. Software trims the clock rate by changing the addend: the nominal value is round(1e9 · 2^32 / (f_clk · increment)), and a signed 16-bit trim c turns it into addend + (addend · c >> 16). A typical increment is 10, 20 or 50 ns.

Software talks to the block through a small register interface: a write port, and a read port with combinational read data. The addend, the time set and the time adjust all pass through staging registers. Each of them is committed by a self-clearing request bit in the control register. A target-time comparator raises a sticky status flag once the running time reaches or passes a programmed target. That flag drives a maskable interrupt.

Register map (word addresses): 0 control, 1 status, 2 current seconds, 3 current nanoseconds, 4 staged addend, 5 increment, 6 staged seconds, 7 staged nanoseconds, 8 target seconds, 9 target nanoseconds.

Top module: `ptp_time_gen`

## Requirements
- R1: On each enabled cycle the active addend is summed into a 32-bit accumulator. The nanoseconds field grows by the increment (address 5) only on a cycle where that sum carries out. With addend 0x8000_0000 and increment 10, any 20 enabled cycles advance the time by exactly 100 ns. With addend 0x4000_0000, any 40 enabled cycles advance it by exactly 100 ns.
- R2: When an increment takes the nanoseconds field to 1,000,000,000 or beyond, the field drops by 1,000,000,000 and the seconds field rises by one.
- R3: Setting control bit 1 (init request) copies the staged seconds (address 6) and the staged nanoseconds (address 7, bits 29:0) into the time in a single enabled cycle. Bit 1 reads 1 until that cycle and then clears by itself.
- R4: Setting control bit 2 (adjust request) adds the staged offset to the time, or subtracts it when bit 31 of the staged nanoseconds word is 1. Nanoseconds carry into the seconds field or borrow from it, so that 8.4 s − 0.6 s gives 7.8 s. Bit 2 clears by itself after the adjust.
- R5: A request on bit 1 or bit 2 is accepted only while both bits read 0, and requests written at other times are dropped. If bits 1 and 2 are written together, the init is taken and the adjust is dropped.
- R6: A write to address 4 only stages an addend. The addend starts to drive the accumulator only after control bit 0 (addend load) is set. Bit 0 reads 1 for one enabled cycle and then clears by itself.
- R7: Control bit 4 is the global enable. While it is 0, the time and the accumulator hold their values, and pending requests stay pending until it is set again.
- R8: Control bit 3 arms the target comparator and reads 1 while armed. When the time equals or passes the target (addresses 8 and 9), status bit 0 is set and bit 3 clears. The comparator then stays quiet until it is armed again.
- R9: The irq output is status bit 0 gated by control bit 5 (mask): irq is 1 only while the status bit is 1 and the mask is 0.
- R10: A read of address 1 with rd_en high clears status bit 0 on the following clock.
- R11: After reset the time, the active addend, the accumulator, all staged values and all control and status bits are zero, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; a strobe on the status address clears the status flag |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Target-time interrupt, status flag gated by the mask |

## Verification
A wrong accumulator or a wrong active addend shows up as a wrong rate. The bench measures the time over a fixed window of 20 or 40 cycles and compares it with an exact count, so an error of a single carry in the window is caught. A wrong nanoseconds wrap, carry or borrow gives a wrong seconds or nanoseconds word on the first read after the operation, one cycle after the request is latched. A handshake bit that sticks or clears early shows in the control register within one cycle. A comparator that fires early, late or twice shows as a status or irq value that is wrong at a checkpoint placed before the target, after it, or after the flag has been cleared.

// File: rtl/ptp_tg_pkg.sv
// Shared definitions for the PTP system time generator.
// Holds the register word addresses, the control bit positions and the
// operation code that passes from the register block to the time counter.
package ptp_tg_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 4'd0,
        RA_STATUS  = 4'd1,
        RA_SEC     = 4'd2,
        RA_NS      = 4'd3,
        RA_ADDEND  = 4'd4,
        RA_INCR    = 4'd5,
        RA_STG_SEC = 4'd6,
        RA_STG_NS  = 4'd7,
        RA_TGT_SEC = 4'd8,
        RA_TGT_NS  = 4'd9
    } reg_addr_e;

    localparam int unsigned CB_ADDEND = 0;
    localparam int unsigned CB_INIT   = 1;
    localparam int unsigned CB_ADJ    = 2;
    localparam int unsigned CB_ARM    = 3;
    localparam int unsigned CB_EN     = 4;
    localparam int unsigned CB_MASK   = 5;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INIT = 2'd1,
        OP_ADD  = 2'd2,
        OP_SUB  = 2'd3
    } tod_op_e;

endpackage

// File: rtl/ptp_acc_tick.sv
// Phase accumulator of the time generator.
// On each enabled cycle the active addend is summed into the accumulator, and
// the carry out of that sum is the tick that advances the nanoseconds field.
// A staged addend becomes active on an enabled cycle with load_pend high.
// Assumes: load_pend stays high until load_done is seen.
module ptp_acc_tick #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] addend_stg,
    input  logic             load_pend,
    output logic             load_done,
    output logic             tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W:0]   sum;

    // Accumulator sum with carry out
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, addend_q};
    end

    assign tick      = en & sum[ACC_W];
    assign load_done = en & load_pend;

    // Accumulator and active-addend registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            addend_q <= '0;
        end else if (en) begin
            acc_q <= sum[ACC_W-1:0];
            if (load_pend) begin
                addend_q <= addend_stg;
            end
        end
    end

    // A carry leaves the accumulator smaller than before
    p_tick_wraps_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (acc_q < $past(acc_q)));

    // Nothing moves while the enable is low
    p_acc_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q) && $stable(addend_q));

endmodule

// File: rtl/ptp_tod_counter.sv
// Time-of-day counter: a seconds word and a nanoseconds word.
// On an enabled cycle it applies one of: load the staged time (init), add or
// subtract the staged offset, or an increment on tick. A requested operation
// takes the place of the tick on that cycle.
// Assumes: off_ns and the running nanoseconds are below NS_PER_SEC, and
// incr is below NS_PER_SEC.
module ptp_tod_counter
    import ptp_tg_pkg::*;
#(
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned NS_W       = 30,
    parameter int unsigned INC_W      = 8,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [INC_W-1:0] incr,
    input  tod_op_e          op,
    input  logic [SEC_W-1:0] off_sec,
    input  logic [NS_W-1:0]  off_ns,
    output logic [SEC_W-1:0] sec,
    output logic [NS_W-1:0]  ns
);

    localparam logic [NS_W:0] NPS = (NS_W+1)'(NS_PER_SEC);

    logic [SEC_W-1:0] sec_q, sec_d;
    logic [NS_W-1:0]  ns_q, ns_d;
    logic [NS_W:0]    tick_sum, tick_wrap;
    logic [NS_W:0]    add_sum, add_wrap;
    logic [NS_W:0]    sub_plain, sub_borrow;
    logic             borrow;

    // Candidate nanosecond results for each operation
    always_comb begin
        tick_sum   = {1'b0, ns_q} + (NS_W+1)'(incr);
        tick_wrap  = tick_sum - NPS;
        add_sum    = {1'b0, ns_q} + {1'b0, off_ns};
        add_wrap   = add_sum - NPS;
        borrow     = (ns_q < off_ns);
        sub_plain  = {1'b0, ns_q} - {1'b0, off_ns};
        sub_borrow = {1'b0, ns_q} + NPS - {1'b0, off_ns};
    end

    // Next-state selection by operation
    always_comb begin
        sec_d = sec_q;
        ns_d  = ns_q;
        unique case (op)
            OP_INIT: begin
                sec_d = off_sec;
                ns_d  = off_ns;
            end
            OP_ADD: begin
                if (add_sum >= NPS) begin
                    sec_d = sec_q + off_sec + SEC_W'(1);
                    ns_d  = add_wrap[NS_W-1:0];
                end else begin
                    sec_d = sec_q + off_sec;
                    ns_d  = add_sum[NS_W-1:0];
                end
            end
            OP_SUB: begin
                if (borrow) begin
                    sec_d = sec_q - off_sec - SEC_W'(1);
                    ns_d  = sub_borrow[NS_W-1:0];
                end else begin
                    sec_d = sec_q - off_sec;
                    ns_d  = sub_plain[NS_W-1:0];
                end
            end
            default: begin
                if (tick) begin
                    if (tick_sum >= NPS) begin
                        sec_d = sec_q + SEC_W'(1);
                        ns_d  = tick_wrap[NS_W-1:0];
                    end else begin
                        ns_d  = tick_sum[NS_W-1:0];
                    end
                end
            end
        endcase
    end

    // Time registers, gated by the global enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (en) begin
            sec_q <= sec_d;
            ns_q  <= ns_d;
        end
    end

    assign sec = sec_q;
    assign ns  = ns_q;

    // Nanoseconds never reach one second
    p_ns_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NPS[NS_W-1:0]);

    // Init copies the staged words in one cycle
    p_init_load_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_INIT) |=> (sec_q == $past(off_sec)) && (ns_q == $past(off_ns)));

    // Disabled counter holds its value
    p_tod_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sec_q) && $stable(ns_q));

endmodule

// File: rtl/ptp_target_cmp.sv
// Target-time comparator.
// While armed, it compares the running time with the target. On the first
// cycle the time equals or passes the target it sets the sticky status flag
// and disarms itself. A read-clear pulse drops the flag; a fire in the same
// cycle wins.
// Assumes: arm_set and clr_rd are single-cycle pulses from the register block.
module ptp_target_cmp #(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [NS_W-1:0]  cur_ns,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    input  logic             arm_set,
    input  logic             clr_rd,
    output logic             armed,
    output logic             status
);

    logic armed_q, status_q;
    logic reached, fire;

    // Time at or beyond the target
    always_comb begin
        reached = (cur_sec > tgt_sec) || ((cur_sec == tgt_sec) && (cur_ns >= tgt_ns));
        fire    = armed_q && reached;
    end

    // Arm state: fire disarms, otherwise an arm request arms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (fire) begin
            armed_q <= 1'b0;
        end else if (arm_set) begin
            armed_q <= 1'b1;
        end
    end

    // Sticky status: set on fire, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (fire) begin
            status_q <= 1'b1;
        end else if (clr_rd) begin
            status_q <= 1'b0;
        end
    end

    assign armed  = armed_q;
    assign status = status_q;

    // Firing sets the flag and disarms
    p_fire_disarm_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> status_q && !armed_q);

    // The flag only rises through a fire
    p_status_source_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(armed_q));

    // A status read with no fire clears the flag
    p_status_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !fire) |=> !status_q);

endmodule

// File: rtl/ptp_time_gen.sv
// PTP system time generator: top level and register block.
// Decodes the register writes, holds the staged values and the self-clearing
// request bits, and connects the accumulator, the time counter and the target
// comparator. Read data is combinational from rd_addr.
// Assumes: software keeps staged and target nanoseconds below NS_PER_SEC.
module ptp_time_gen
    import ptp_tg_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned NS_W       = 30,
    parameter int unsigned INC_W      = 8,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned SIGN_BIT = DATA_W - 1;

    logic [ACC_W-1:0]  addend_stg_q;
    logic [INC_W-1:0]  incr_q;
    logic [SEC_W-1:0]  stg_sec_q;
    logic [DATA_W-1:0] stg_ns_q;
    logic [SEC_W-1:0]  tgt_sec_q;
    logic [NS_W-1:0]   tgt_ns_q;
    logic              en_q, mask_q;
    logic              pend_addend_q, pend_init_q, pend_adj_q;

    logic              ctrl_wr, cmd_free, arm_set, clr_rd;
    logic              load_done, tick, armed, status;
    tod_op_e           op;
    logic [SEC_W-1:0]  cur_sec;
    logic [NS_W-1:0]   cur_ns;
    logic [DATA_W-1:0] ctrl_view;

    assign ctrl_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
    assign cmd_free = !pend_init_q && !pend_adj_q;
    assign arm_set  = ctrl_wr && wr_data[CB_ARM];
    assign clr_rd   = rd_en && (reg_addr_e'(rd_addr) == RA_STATUS);

    // Staging, target and increment registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_stg_q <= '0;
            incr_q       <= '0;
            stg_sec_q    <= '0;
            stg_ns_q     <= '0;
            tgt_sec_q    <= '0;
            tgt_ns_q     <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_ADDEND:  addend_stg_q <= wr_data[ACC_W-1:0];
                RA_INCR:    incr_q       <= wr_data[INC_W-1:0];
                RA_STG_SEC: stg_sec_q    <= wr_data[SEC_W-1:0];
                RA_STG_NS:  stg_ns_q     <= wr_data;
                RA_TGT_SEC: tgt_sec_q    <= wr_data[SEC_W-1:0];
                RA_TGT_NS:  tgt_ns_q     <= wr_data[NS_W-1:0];
                default: ;
            endcase
        end
    end

    // Persistent control bits: global enable and interrupt mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= wr_data[CB_EN];
            mask_q <= wr_data[CB_MASK];
        end
    end

    // Addend-load request bit: set by software, cleared once loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addend_q <= 1'b0;
        end else if (ctrl_wr && wr_data[CB_ADDEND] && !pend_addend_q) begin
            pend_addend_q <= 1'b1;
        end else if (load_done) begin
            pend_addend_q <= 1'b0;
        end
    end

    // Init and adjust request bits: accepted only while both are clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_init_q <= 1'b0;
            pend_adj_q  <= 1'b0;
        end else if (ctrl_wr && cmd_free && (wr_data[CB_INIT] || wr_data[CB_ADJ])) begin
            pend_init_q <= wr_data[CB_INIT];
            pend_adj_q  <= !wr_data[CB_INIT];
        end else if (en_q) begin
            pend_init_q <= 1'b0;
            pend_adj_q  <= 1'b0;
        end
    end

    // Operation offered to the time counter
    always_comb begin
        if (pend_init_q) begin
            op = OP_INIT;
        end else if (pend_adj_q) begin
            op = stg_ns_q[SIGN_BIT] ? OP_SUB : OP_ADD;
        end else begin
            op = OP_NONE;
        end
    end

    ptp_acc_tick #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .addend_stg (addend_stg_q),
        .load_pend  (pend_addend_q),
        .load_done  (load_done),
        .tick       (tick)
    );

    ptp_tod_counter #(
        .SEC_W      (SEC_W),
        .NS_W       (NS_W),
        .INC_W      (INC_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_tod (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .tick    (tick),
        .incr    (incr_q),
        .op      (op),
        .off_sec (stg_sec_q),
        .off_ns  (stg_ns_q[NS_W-1:0]),
        .sec     (cur_sec),
        .ns      (cur_ns)
    );

    ptp_target_cmp #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_sec (cur_sec),
        .cur_ns  (cur_ns),
        .tgt_sec (tgt_sec_q),
        .tgt_ns  (tgt_ns_q),
        .arm_set (arm_set),
        .clr_rd  (clr_rd),
        .armed   (armed),
        .status  (status)
    );

    // Control register view
    always_comb begin
        ctrl_view            = '0;
        ctrl_view[CB_ADDEND] = pend_addend_q;
        ctrl_view[CB_INIT]   = pend_init_q;
        ctrl_view[CB_ADJ]    = pend_adj_q;
        ctrl_view[CB_ARM]    = armed;
        ctrl_view[CB_EN]     = en_q;
        ctrl_view[CB_MASK]   = mask_q;
    end

    // Combinational read multiplexer
    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_CTRL:    rd_data = ctrl_view;
            RA_STATUS:  rd_data = DATA_W'(status);
            RA_SEC:     rd_data = DATA_W'(cur_sec);
            RA_NS:      rd_data = DATA_W'(cur_ns);
            RA_ADDEND:  rd_data = DATA_W'(addend_stg_q);
            RA_INCR:    rd_data = DATA_W'(incr_q);
            RA_STG_SEC: rd_data = DATA_W'(stg_sec_q);
            RA_STG_NS:  rd_data = stg_ns_q;
            RA_TGT_SEC: rd_data = DATA_W'(tgt_sec_q);
            RA_TGT_NS:  rd_data = DATA_W'(tgt_ns_q);
            default:    rd_data = '0;
        endcase
    end

    assign irq = status & ~mask_q;

    // An enabled init request completes in one cycle
    p_init_clear_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (pend_init_q && en_q) |=> !pend_init_q);

    // Init and adjust are never pending together
    p_cmd_excl_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_init_q && pend_adj_q));

    // A request written while another is pending is not taken
    p_cmd_drop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (pend_init_q && en_q) |=> !pend_adj_q);

    // An enabled addend load completes in one cycle
    p_addend_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (pend_addend_q && en_q) |=> !pend_addend_q);

    // Disabled block keeps its requests pending
    p_req_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && pend_init_q) |=> pend_init_q);

endmodule

// File: tb/ptp_time_gen_test.sv
// Directed bench for the PTP system time generator. Each task covers one
// scenario and checks its own results through the register interface.
module ptp_time_gen_test;

    localparam logic [3:0] A_CTRL = 4'd0, A_STATUS = 4'd1, A_SEC = 4'd2, A_NS = 4'd3,
                           A_ADDEND = 4'd4, A_INCR = 4'd5, A_SSEC = 4'd6, A_SNS = 4'd7,
                           A_TSEC = 4'd8, A_TNS = 4'd9;
    localparam logic [3:0] C_LOAD = 4'b0001, C_INIT = 4'b0010, C_ADJ = 4'b0100, C_ARM = 4'b1000;
    localparam longint unsigned NPS = 64'd1000000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  en_s    = 1'b0;
    bit  mask_s  = 1'b0;

    ptp_time_gen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
        end
    endtask

    // One register write: drive at a falling edge, latched on the next rise
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ctrl(input logic [3:0] cmd);
        wr(A_CTRL, {26'd0, mask_s, en_s, cmd});
    endtask

    task automatic rd_clr(output logic [31:0] d);
        rd_addr = A_STATUS; rd_en = 1'b1;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] n);
        wr(A_SSEC, s);
        wr(A_SNS, n);
        ctrl(C_INIT);
        @(negedge clk);
    endtask

    task automatic chk_time(input string tag, input logic [31:0] s, input logic [31:0] n);
        logic [31:0] d;
        rd(A_SEC, d); check({tag, " sec"}, d, s);
        rd(A_NS, d);  check({tag, " ns"}, d, n);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d);   check("R11 ctrl", d, 0);
        rd(A_STATUS, d); check("R11 status", d, 0);
        chk_time("R11 time", 0, 0);
        rd(A_ADDEND, d); check("R11 addend", d, 0);
        check("R11 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_init;
        logic [31:0] d;
        en_s = 1'b1;
        wr(A_SSEC, 5); wr(A_SNS, 123);
        ctrl(C_INIT);
        rd(A_CTRL, d); check("R3 init bit pending", {31'd0, d[1]}, 1);
        @(negedge clk);
        rd(A_CTRL, d); check("R3 init bit clears", {31'd0, d[1]}, 0);
        chk_time("R3 set", 5, 123);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        en_s = 1'b0;
        wr(A_SSEC, 9); wr(A_SNS, 456);
        ctrl(C_INIT);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd(A_CTRL, d); check("R7 init pends while off", {31'd0, d[1]}, 1);
            rd(A_NS, d);   check("R7 ns held while off", d, 123);
        end
        en_s = 1'b1;
        ctrl(4'd0);
        @(negedge clk);
        chk_time("R7 pending init applied on enable", 9, 456);
    endtask

    task automatic t_adjust;
        set_time(5, 700000000);
        wr(A_SSEC, 2); wr(A_SNS, 600000000);
        ctrl(C_ADJ); @(negedge clk);
        chk_time("R4 add with carry", 8, 300000000);
        wr(A_SSEC, 0); wr(A_SNS, 100000000);
        ctrl(C_ADJ); @(negedge clk);
        chk_time("R4 add no carry", 8, 400000000);
        wr(A_SNS, 32'h8000_0000 | 32'd600000000);
        ctrl(C_ADJ); @(negedge clk);
        chk_time("R4 subtract with borrow", 7, 800000000);
        wr(A_SSEC, 3); wr(A_SNS, 32'h8000_0000 | 32'd100000000);
        ctrl(C_ADJ); @(negedge clk);
        chk_time("R4 subtract no borrow", 4, 700000000);
    endtask

    task automatic t_excl;
        logic [31:0] d;
        set_time(1, 0);
        wr(A_SSEC, 10); wr(A_SNS, 0);
        // Back-to-back: init, then adjust while init is still pending
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = {26'd0, mask_s, en_s, C_INIT};
        @(negedge clk);
        wr_data = {26'd0, mask_s, en_s, C_ADJ};
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk_time("R5 adjust during init dropped", 10, 0);
        rd(A_CTRL, d); check("R5 no request left", {29'd0, d[2:0]}, 0);
        wr(A_SSEC, 3);
        ctrl(C_INIT | C_ADJ);
        @(negedge clk); @(negedge clk);
        chk_time("R5 init wins over adjust", 3, 0);
    endtask

    task automatic t_addend;
        logic [31:0] d, n0, n1;
        set_time(0, 0);
        wr(A_INCR, 10);
        wr(A_ADDEND, 32'h8000_0000);
        repeat (10) @(negedge clk);
        rd(A_NS, d); check("R6 staged addend inactive", d, 0);
        ctrl(C_LOAD);
        rd(A_CTRL, d); check("R6 load bit pending", {31'd0, d[0]}, 1);
        @(negedge clk);
        rd(A_CTRL, d); check("R6 load bit clears", {31'd0, d[0]}, 0);
        rd(A_NS, n0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(A_NS, n1);
        check("R1 rate half addend", n1 - n0, 100);
        wr(A_ADDEND, 32'h4000_0000);
        ctrl(C_LOAD);
        @(negedge clk);
        rd(A_NS, n0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        rd(A_NS, n1);
        check("R1 rate quarter addend", n1 - n0, 100);
        wr(A_ADDEND, 32'h8000_0000);
        ctrl(C_LOAD);
    endtask

    task automatic t_wrap;
        logic [31:0] s0, n0, s1, n1;
        longint unsigned total;
        set_time(3, 999999950);
        en_s = 1'b0; ctrl(4'd0);
        rd(A_SEC, s0); rd(A_NS, n0);
        en_s = 1'b1; ctrl(4'd0);
        // 18 more falling edges, then the disabling write latches 20 rises after enabling
        repeat (18) @(negedge clk);
        en_s = 1'b0; ctrl(4'd0);
        rd(A_SEC, s1); rd(A_NS, n1);
        total = longint'(s0) * NPS + longint'(n0) + 64'd100;
        check("R2 seconds after wrap", s1, 32'(total / NPS));
        check("R2 ns after wrap", n1, 32'(total % NPS));
        en_s = 1'b1; ctrl(4'd0);
    endtask

    task automatic t_target;
        logic [31:0] d;
        set_time(1, 0);
        wr(A_TSEC, 1); wr(A_TNS, 500);
        ctrl(C_ARM);
        rd(A_STATUS, d); check("R8 no status before target", d, 0);
        rd(A_CTRL, d);   check("R8 armed", {31'd0, d[3]}, 1);
        repeat (120) @(negedge clk);
        rd(A_STATUS, d); check("R8 status after target", d, 1);
        rd(A_CTRL, d);   check("R8 arm self-clears", {31'd0, d[3]}, 0);
        check("R9 irq unmasked", {31'd0, irq}, 1);
        rd_clr(d);       check("R10 status seen on read", d, 1);
        rd(A_STATUS, d); check("R10 status cleared by read", d, 0);
        check("R10 irq drops", {31'd0, irq}, 0);
        repeat (20) @(negedge clk);
        rd(A_STATUS, d); check("R8 no refire without arm", d, 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        mask_s = 1'b1;
        ctrl(C_ARM);
        @(negedge clk);
        rd(A_STATUS, d); check("R8 past target fires", d, 1);
        check("R9 irq masked", {31'd0, irq}, 0);
        mask_s = 1'b0;
        ctrl(4'd0);
        check("R9 irq after unmask", {31'd0, irq}, 1);
        rd_clr(d);
        rd(A_STATUS, d); check("R10 cleared after unmask", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_init;
        t_hold;
        t_adjust;
        t_excl;
        t_addend;
        t_wrap;
        t_target;
        t_mask;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule